// File: doc/BRIEF.md
# Field-Configurable AND-OR Logic Array

This block is a run-time configurable sum-of-products array. Sixteen input signals feed forty-eight product terms. Eight output functions are formed from those terms. For every product term, a 2-bit code per input chooses whether the input takes part as itself, takes part inverted, or is left out. A connection matrix picks which product terms are summed into each output. A per-output polarity bit can invert the sum. Once configured, the path from inputs to outputs holds no register.

The configuration is shifted in serially, MSB first, while a load enable is high. It takes effect only when a commit strobe arrives with the load enable low. An active-low chip enable inhibits every output, so several arrays can share a bus or split a wider input space. Each output bit leaves the block as a pad value and a pad output-enable pair. A parameter selects the pad behaviour. In the three-state variant, an enabled pad drives the function value. In the open-drain variant, the pad only ever pulls low and otherwise releases the line.

Top module: `pla_array`

## Requirements
- R1: Each input takes part in a product term according to its 2-bit code at configuration bits [2*(t*16+i)+1 : 2*(t*16+i)] (term t, input i). Code 00 means the input is ignored, 01 means the term needs the input high, and 10 means the term needs the input low. The term is the AND of all its literals.
- R2: Code 11 for any input makes that product term permanently false, whatever the inputs.
- R3: A product term whose inputs are all coded 00 is true. An output with no product term connected has a sum of 0 before its polarity stage.
- R4: Configuration bit 1536+o*48+t set to 1 connects term t into the OR sum of output o, and any subset of terms may be connected. Bit 1920+o set to 1 inverts output o after its sum.
- R5: The 1928-bit configuration is shifted in MSB first, one bit per clock while ld_en_i is high. It becomes active only on a clock where commit_i is high and ld_en_i is low. A commit while ld_en_i is high is ignored, and the previous configuration stays active.
- R6: All outputs are inhibited (pad_oe_o all 0) from reset until the first accepted commit, and in every cycle while ld_en_i is high.
- R7: While ce_n_i is high, all outputs are inhibited, regardless of the array contents.
- R8: In the three-state variant (OPEN_DRAIN=0), an active output has pad_oe_o=1 and pad_val_o equal to its function value.
- R9: In the open-drain variant (OPEN_DRAIN=1), pad_val_o is always 0 and pad_oe_o is 1 exactly when the output is active and its function value is 0.
- R10: With a configuration active, outputs follow inputs combinationally, within the same clock cycle and with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en_i | input | 1 | Load enable for the serial configuration chain |
| ld_bit_i | input | 1 | Serial configuration data, MSB first |
| commit_i | input | 1 | Makes the shifted configuration active |
| in_i | input | 16 | Array input variables |
| ce_n_i | input | 1 | Active-low chip enable |
| pad_val_o | output | 8 | Value each output pad drives when enabled |
| pad_oe_o | output | 8 | Per-output pad drive enable |

## Verification
The assertions check on every cycle that load enable and a high chip enable hold all pads inhibited. They also check that the active configuration changes only on an accepted commit, that the serial chain takes the incoming bit, and that a term with a forbidden code stays false. For the variant in use, they check that the three-state pads enable together and that open-drain pads never drive high. Only the bench's scenarios can show that the sum-of-products results are right: the literal coding, the empty-term and empty-sum cases, the polarity inversion, and the response to input changes with no clock edge. The bench scenarios also show that an aborted load with an ignored commit leaves the previous functions intact.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic [1:0] {
    LIT_IGNORE = 2'b00,
    LIT_TRUE   = 2'b01,
    LIT_COMP   = 2'b10,
    LIT_DEAD   = 2'b11
  } lit_code_e;

  function automatic int unsigned cfg_bits(int unsigned n_in, int unsigned n_pt,
                                           int unsigned n_out);
    return n_pt * n_in * 2 + n_pt * n_out + n_out;
  endfunction

endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
  parameter int unsigned CFG_W = 1928
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en_i,
  input  logic             ld_bit_i,
  input  logic             commit_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             valid_o
);

  logic [CFG_W-1:0] shift_q, shift_d;
  logic [CFG_W-1:0] active_q, active_d;
  logic             valid_q, valid_d;
  logic             take;

  // Next-state logic
  always_comb begin
    take     = commit_i & ~ld_en_i;
    shift_d  = shift_q;
    active_d = active_q;
    valid_d  = valid_q;
    if (ld_en_i) shift_d = {shift_q[CFG_W-2:0], ld_bit_i};
    if (take) begin
      active_d = shift_q;
      valid_d  = 1'b1;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q  <= '0;
      active_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      shift_q  <= shift_d;
      active_q <= active_d;
      valid_q  <= valid_d;
    end
  end

  assign cfg_o   = active_q;
  assign valid_o = valid_q;

  // R5: active configuration moves only on an accepted commit
  p_hold_without_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_i && !ld_en_i) |=> $stable(active_q));
  // R5: serial chain takes the incoming bit at its LSB end
  p_shift_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en_i |=> shift_q[0] == $past(ld_bit_i));
  // R6: once configured, stays configured
  p_valid_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> valid_q);

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int unsigned N_IN = 16,
  parameter int unsigned N_PT = 48
) (
  input  logic [N_PT*N_IN*2-1:0] and_cfg_i,
  input  logic [N_IN-1:0]        in_i,
  output logic [N_PT-1:0]        term_o
);

  for (genvar t = 0; t < N_PT; t++) begin : g_term
    logic [N_IN-1:0] lit_ok;
    logic [N_IN-1:0] dead;
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      logic [1:0] code;
      assign code      = and_cfg_i[2*(t*N_IN+i) +: 2];
      // bit0 demands the input high, bit1 demands it low
      assign lit_ok[i] = ~(code[0] & ~in_i[i]) & ~(code[1] & in_i[i]);
      assign dead[i]   = (code == LIT_DEAD);
    end
    assign term_o[t] = &lit_ok;

    // R2: a term holding a forbidden code never fires
    always_comb begin
      if (|dead) p_dead_term_r2: assert (term_o[t] == 1'b0);
    end
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int unsigned N_PT  = 48,
  parameter int unsigned N_OUT = 8
) (
  input  logic [N_OUT*N_PT-1:0] or_cfg_i,
  input  logic [N_OUT-1:0]      pol_i,
  input  logic [N_PT-1:0]       term_i,
  output logic [N_OUT-1:0]      func_o
);

  for (genvar o = 0; o < N_OUT; o++) begin : g_sum
    logic sum;
    assign sum       = |(term_i & or_cfg_i[o*N_PT +: N_PT]);
    assign func_o[o] = sum ^ pol_i[o];
  end

endmodule

// File: rtl/pla_out_stage.sv
module pla_out_stage #(
  parameter int unsigned N_OUT      = 8,
  parameter bit          OPEN_DRAIN = 1'b0
) (
  input  logic             active_i,
  input  logic [N_OUT-1:0] func_i,
  output logic [N_OUT-1:0] pad_val_o,
  output logic [N_OUT-1:0] pad_oe_o
);

  if (OPEN_DRAIN) begin : g_od
    assign pad_val_o = '0;
    assign pad_oe_o  = active_i ? ~func_i : '0;
  end else begin : g_ts
    assign pad_val_o = active_i ? func_i : '0;
    assign pad_oe_o  = {N_OUT{active_i}};
  end

endmodule

// File: rtl/pla_array.sv
module pla_array
  import pla_pkg::*;
#(
  parameter int unsigned N_IN       = 16,
  parameter int unsigned N_PT       = 48,
  parameter int unsigned N_OUT      = 8,
  parameter bit          OPEN_DRAIN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en_i,
  input  logic             ld_bit_i,
  input  logic             commit_i,
  input  logic [N_IN-1:0]  in_i,
  input  logic             ce_n_i,
  output logic [N_OUT-1:0] pad_val_o,
  output logic [N_OUT-1:0] pad_oe_o
);

  localparam int unsigned AND_W = N_PT * N_IN * 2;
  localparam int unsigned OR_W  = N_PT * N_OUT;
  localparam int unsigned CFG_W = cfg_bits(N_IN, N_PT, N_OUT);

  logic [CFG_W-1:0] cfg;
  logic             cfg_valid;
  logic [N_PT-1:0]  term;
  logic [N_OUT-1:0] func;
  logic             active;

  pla_cfg_chain #(.CFG_W(CFG_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en_i  (ld_en_i),
    .ld_bit_i (ld_bit_i),
    .commit_i (commit_i),
    .cfg_o    (cfg),
    .valid_o  (cfg_valid)
  );

  pla_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
    .and_cfg_i (cfg[AND_W-1:0]),
    .in_i      (in_i),
    .term_o    (term)
  );

  pla_or_plane #(.N_PT(N_PT), .N_OUT(N_OUT)) u_or (
    .or_cfg_i (cfg[AND_W +: OR_W]),
    .pol_i    (cfg[AND_W+OR_W +: N_OUT]),
    .term_i   (term),
    .func_o   (func)
  );

  assign active = cfg_valid & ~ld_en_i & ~ce_n_i;

  pla_out_stage #(.N_OUT(N_OUT), .OPEN_DRAIN(OPEN_DRAIN)) u_out (
    .active_i  (active),
    .func_i    (func),
    .pad_val_o (pad_val_o),
    .pad_oe_o  (pad_oe_o)
  );

  // R6: loading keeps every pad released
  p_load_inhibit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en_i |-> pad_oe_o == '0);
  // R7: deasserted chip enable keeps every pad released
  p_ce_inhibit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n_i |-> pad_oe_o == '0);

  if (OPEN_DRAIN) begin : g_chk_od
    // R9: open-drain pads never drive a high level
    p_od_low_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pad_val_o == '0);
  end else begin : g_chk_ts
    // R8: three-state pads are enabled all together or not at all
    p_ts_uniform_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe_o == '0) || (pad_oe_o == '1));
  end

endmodule

// File: tb/sim_pla_array.sv
module sim_pla_array;

  localparam int CFG_W  = 1928;
  localparam int OR_B   = 1536;
  localparam int POL_B  = 1920;
  localparam int NVEC   = 11;

  // R1 R3 R4: vectors for config A
  localparam logic [15:0] VEC_IN [NVEC] = '{
    16'h0000, 16'h0003, 16'h0004, 16'h0010, 16'h0020, 16'h4000,
    16'hC000, 16'hFFFF, 16'h0001, 16'h4033, 16'h0008 };
  localparam logic [7:0]  VEC_EXP [NVEC] = '{
    8'h04, 8'h45, 8'h06, 8'h24, 8'h24, 8'hC4,
    8'h04, 8'h67, 8'h04, 8'hE5, 8'h04 };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic        ld_bit = 1'b0;
  logic        commit = 1'b0;
  logic [15:0] in_v = '0;
  logic        ce_n = 1'b0;
  logic [7:0]  val0, oe0, val1, oe1;
  logic [CFG_W-1:0] cfg_a, cfg_b;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pla_array #(.OPEN_DRAIN(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_en_i(ld_en), .ld_bit_i(ld_bit),
    .commit_i(commit), .in_i(in_v), .ce_n_i(ce_n),
    .pad_val_o(val0), .pad_oe_o(oe0));

  pla_array #(.OPEN_DRAIN(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .ld_en_i(ld_en), .ld_bit_i(ld_bit),
    .commit_i(commit), .in_i(in_v), .ce_n_i(ce_n),
    .pad_val_o(val1), .pad_oe_o(oe1));

  task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_cfg(input logic [CFG_W-1:0] c, input int nbits, input logic cmt);
    for (int k = CFG_W - 1; k >= CFG_W - nbits; k--) begin
      @(negedge clk);
      ld_en  = 1'b1;
      ld_bit = c[k];
      commit = cmt;
    end
    @(negedge clk);
    ld_en  = 1'b0;
    commit = 1'b0;
  endtask

  task automatic do_commit();
    @(negedge clk);
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
  endtask

  function automatic void set_lit(ref logic [CFG_W-1:0] c, input int t, input int i,
                                  input logic [1:0] code);
    c[2*(t*16+i) +: 2] = code;
  endfunction

  task automatic run_table(input string tag);
    for (int v = 0; v < NVEC; v++) begin
      in_v = VEC_IN[v];
      #1;
      check8(val0, VEC_EXP[v], {tag, " R1/R4 ts value"});
      check8(oe0, 8'hFF, {tag, " R8 ts enable"});
      check8(oe1, ~VEC_EXP[v], {tag, " R9 od enable"});
      check8(val1, 8'h00, {tag, " R9 od value"});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // config A
    cfg_a = '0;
    set_lit(cfg_a, 0, 0, 2'b01); set_lit(cfg_a, 0, 1, 2'b01);   // R1 term0 = in0&in1
    cfg_a[OR_B + 0*48 + 0] = 1'b1;
    set_lit(cfg_a, 1, 2, 2'b10);                                // term1 = !in2
    cfg_a[OR_B + 1*48 + 1] = 1'b1; cfg_a[POL_B + 1] = 1'b1;     // R4 f1 = in2
    cfg_a[OR_B + 2*48 + 2] = 1'b1;                              // R3 all-ignore term
    set_lit(cfg_a, 3, 3, 2'b11);                                // R2 dead term
    cfg_a[OR_B + 4*48 + 3] = 1'b1;
    set_lit(cfg_a, 4, 4, 2'b01); set_lit(cfg_a, 5, 5, 2'b01);
    cfg_a[OR_B + 5*48 + 4] = 1'b1; cfg_a[OR_B + 5*48 + 5] = 1'b1;
    set_lit(cfg_a, 47, 14, 2'b01); set_lit(cfg_a, 47, 15, 2'b10);
    cfg_a[OR_B + 7*48 + 47] = 1'b1;
    cfg_a[OR_B + 6*48 + 0] = 1'b1; cfg_a[OR_B + 6*48 + 47] = 1'b1;
    // config B: no terms connected, every output inverted
    cfg_b = '0;
    for (int o = 0; o < 8; o++) cfg_b[POL_B + o] = 1'b1;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check8(oe0, 8'h00, "R6 reset ts inhibited");
    check8(oe1, 8'h00, "R6 reset od released");

    shift_cfg(cfg_a, CFG_W, 1'b0);
    in_v = 16'h0003; #1;
    check8(oe0, 8'h00, "R5 loaded but uncommitted");
    do_commit();
    run_table("R5 cfgA");

    // R10: input changes with no clock edge between them
    @(negedge clk);
    in_v = 16'h0003; #1;
    check8(val0, 8'h45, "R10 first value");
    in_v = 16'h0004; #1;
    check8(val0, 8'h06, "R10 same-cycle update");

    // R7
    ce_n = 1'b1; #1;
    check8(oe0, 8'h00, "R7 ts inhibited by ce_n");
    check8(oe1, 8'h00, "R7 od released by ce_n");
    ce_n = 1'b0; #1;
    check8(oe0, 8'hFF, "R7 ts re-enabled");

    // R6 + R5: partial reload with commit held high during load
    fork
      shift_cfg(cfg_b, 100, 1'b1);
      begin
        repeat (50) @(negedge clk);
        #1;
        check8(oe0, 8'h00, "R6 inhibited during load");
      end
    join
    run_table("R5 ignored commit keeps cfgA");

    // config B
    shift_cfg(cfg_b, CFG_W, 1'b0);
    do_commit();
    in_v = 16'hA5A5; #1;
    check8(val0, 8'hFF, "R3/R4 empty sums inverted");
    check8(oe1, 8'h00, "R9 od released on ones");
    in_v = 16'h0000; #1;
    check8(val0, 8'hFF, "R3 empty sum independent of inputs");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule